// File: doc/BRIEF.md
# USB Endpoint Packet Buffer Manager

This block connects the byte stream of a USB serial interface engine to one port of a dual-ported packet memory. The CPU owns the other memory port. A register file, written by the CPU, holds a descriptor for each endpoint. Each descriptor has two buffer slots, and each slot has a base address and a byte count (used as a limit on receive). It also has an armed bit per slot, a mode field and a sticky overrun flag.

When the engine raises a request for an endpoint and a direction, the block picks the slot. It refuses the request with a NAK if that slot is not armed or the direction does not fit. Otherwise it streams the packet one byte per clock, advancing the memory address from the slot's base.

On receive, the block stops writing at the slot's limit and reports an overrun instead of success. A successful receive writes the received byte count back into the slot. Endpoints in ping-pong mode alternate between their two slots. The bus can then fill or drain one slot while software handles the other.

Top module: `usb_epbuf_mgr`

## Requirements
- R1: After reset no result or stream strobe is asserted, and every descriptor field reads back as zero: counts, addresses, armed bits, mode and overrun flag.
- R2: Slot choice depends on the mode field (select 4: bit0 ping-pong, bit1 direction is IN, bit2 toggle). In single mode, IN uses slot 0 and OUT uses slot 1. In ping-pong mode, the toggle bit names the slot.
- R3: A request is refused with `reqNak` one cycle later when the chosen slot's armed bit (select 5, bit0 slot 0, bit1 slot 1) is clear, or when a ping-pong endpoint is addressed in the other direction. A refused request moves no data and leaves the descriptor unchanged.
- R4: On OUT, the k-th accepted byte is written at base+k, one byte per clock, with the address wrapping modulo the memory size.
- R5: On IN, the block delivers count bytes read from base upward, in order. `txSop` marks the first byte and `txEop` the last. The byte and strobes hold steady while `txReady` is low. The memory has one cycle of read latency and holds its output while `memRe` is low.
- R6: After a successful OUT, the count field of the filled slot holds the number of bytes received.
- R7: OUT bytes beyond the slot limit are not written. At the end of such a packet `doneOvr` pulses instead of `doneOk`, and the slot's armed bit, count and toggle stay as they were.
- R8: An overrun sets the endpoint's overrun flag (select 6, bit0). The flag survives later successful packets and clears only on a CPU write to select 6.
- R9: A successful packet clears the armed bit of the slot it used, and in ping-pong mode it flips the toggle.
- R10: An IN from a slot with count zero completes with `doneOk` and delivers no byte.
- R11: `reqNak`, `doneOk` and `doneOvr` are single-cycle pulses, and at most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | CPU descriptor write strobe |
| cfgEp | input | EP_W | Endpoint written |
| cfgSel | input | 3 | Field written (0 addr0, 1 cnt0, 2 addr1, 3 cnt1, 4 mode, 5 armed, 6 overrun clear) |
| cfgWdata | input | CFG_W | Write data |
| cfgRdEp | input | EP_W | Endpoint read back |
| cfgRdSel | input | 3 | Field read back (same codes; 6 returns the overrun flag) |
| cfgRdData | output | CFG_W | Read-back data |
| reqValid | input | 1 | Transaction request from the serial engine |
| reqEp | input | EP_W | Requested endpoint |
| reqIn | input | 1 | 1 for IN (to host), 0 for OUT |
| reqNak | output | 1 | Request refused |
| doneOk | output | 1 | Packet completed successfully |
| doneOvr | output | 1 | OUT packet ended in overrun |
| txValid | output | 1 | IN byte valid |
| txReady | input | 1 | Engine accepts IN byte |
| txData | output | 8 | IN byte |
| txSop | output | 1 | First byte of IN packet |
| txEop | output | 1 | Last byte of IN packet |
| rxValid | input | 1 | OUT byte valid |
| rxReady | output | 1 | Block accepts OUT bytes |
| rxData | input | 8 | OUT byte |
| rxEop | input | 1 | Marks the last OUT byte |
| memAddr | output | ADDR_W | Packet memory address |
| memRe | output | 1 | Packet memory read enable |
| memWe | output | 1 | Packet memory write enable |
| memWdata | output | 8 | Packet memory write data |
| memRdata | input | 8 | Packet memory read data |

## Verification
The bench builds the block with four endpoints, a 64-byte packet memory and 7-bit counts. With the small memory, a receive buffer placed near the top spills across address zero, so the wrap is observable. With four endpoints, single-mode IN, single-mode OUT, ping-pong OUT and ping-pong IN can each live on its own endpoint in one run. Stall patterns on `txReady` exercise the hold behaviour of the IN stream. Small limits make overrun, the sticky flag and zero-length IN cheap to reach.

// File: rtl/ubm_pkg.sv
package ubm_pkg;

  typedef enum logic [2:0] {
    FLD_ADDR0 = 3'd0,
    FLD_CNT0  = 3'd1,
    FLD_ADDR1 = 3'd2,
    FLD_CNT1  = 3'd3,
    FLD_MODE  = 3'd4,
    FLD_ARM   = 3'd5,
    FLD_OVR   = 3'd6
  } cfgFld_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_RX   = 2'd2
  } ubmState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture endpoint, slot, base and length
    logic rdIssue;  // read one byte, advance pointer
    logic wrByte;   // write one byte, advance pointer
    logic commit;   // successful end of packet
    logic flagOvr;  // overrun end of packet
  } ubmStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic slotOk;
    logic moreTx;
    logic issueLast;
    logic ptrZero;
    logic roomRx;
  } ubmStatus_t;

endpackage

// File: rtl/ubm_datapath.sv
module ubm_datapath
  import ubm_pkg::*;
#(
  parameter int NUM_EP = 10,
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 10,
  parameter int EP_W   = 4,
  parameter int CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [EP_W-1:0]   cfgEp,
  input  logic [2:0]        cfgSel,
  input  logic [CFG_W-1:0]  cfgWdata,
  input  logic [EP_W-1:0]   cfgRdEp,
  input  logic [2:0]        cfgRdSel,
  output logic [CFG_W-1:0]  cfgRdData,
  input  logic [EP_W-1:0]   reqEp,
  input  logic              reqIn,
  input  logic [7:0]        rxData,
  input  ubmStrobe_t        strobe,
  output ubmStatus_t        status,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata
);

  typedef struct packed {
    logic [1:0][ADDR_W-1:0] addr;
    logic [1:0][CNT_W-1:0]  cnt;
    logic [1:0]             armed;
    logic                   dbl;
    logic                   dirIn;
    logic                   tog;
    logic                   ovr;
  } epDesc_t;

  epDesc_t epTab [NUM_EP];

  // transaction context
  logic [EP_W-1:0]   curEp;
  logic              curSlot;
  logic              curIn;
  logic [ADDR_W-1:0] curBase;
  logic [CNT_W-1:0]  curLen;
  logic [CNT_W-1:0]  ptr;
  logic [CNT_W-1:0]  rxCount;

  assign rxCount = ptr + CNT_W'(strobe.wrByte);

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    epDesc_t d;
    logic cpuHit;
    logic hwHit;
    assign cpuHit = cfgWe && (int'(cfgEp) == e);
    assign hwHit  = (int'(curEp) == e);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        d <= '0;
      end else begin
        if (cpuHit) begin
          case (cfgFld_e'(cfgSel))
            FLD_ADDR0: d.addr[0] <= ADDR_W'(cfgWdata);
            FLD_CNT0:  d.cnt[0]  <= CNT_W'(cfgWdata);
            FLD_ADDR1: d.addr[1] <= ADDR_W'(cfgWdata);
            FLD_CNT1:  d.cnt[1]  <= CNT_W'(cfgWdata);
            FLD_MODE: begin
              d.dbl   <= cfgWdata[0];
              d.dirIn <= cfgWdata[1];
              d.tog   <= cfgWdata[2];
            end
            FLD_ARM:  d.armed <= cfgWdata[1:0];
            FLD_OVR:  d.ovr   <= 1'b0;
            default: ;
          endcase
        end
        if (hwHit && strobe.commit) begin
          d.armed[curSlot] <= 1'b0;
          if (d.dbl) d.tog <= ~d.tog;
          if (!curIn) d.cnt[curSlot] <= rxCount;
        end
        if (hwHit && strobe.flagOvr) d.ovr <= 1'b1;
      end
    end

    assign epTab[e] = d;
  end

  // request decode
  epDesc_t reqDesc;
  logic    reqSlot;
  logic    dirOk;

  always_comb begin
    reqDesc = (int'(reqEp) < NUM_EP) ? epTab[reqEp] : '0;
    reqSlot = reqDesc.dbl ? reqDesc.tog : ~reqIn;
    dirOk   = !reqDesc.dbl || (reqDesc.dirIn == reqIn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curEp   <= '0;
      curSlot <= 1'b0;
      curIn   <= 1'b0;
      curBase <= '0;
      curLen  <= '0;
      ptr     <= '0;
    end else if (strobe.load) begin
      curEp   <= reqEp;
      curSlot <= reqSlot;
      curIn   <= reqIn;
      curBase <= reqDesc.addr[reqSlot];
      curLen  <= reqDesc.cnt[reqSlot];
      ptr     <= '0;
    end else if (strobe.rdIssue || strobe.wrByte) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_comb begin
    status.slotOk    = dirOk && reqDesc.armed[reqSlot];
    status.moreTx    = ptr < curLen;
    status.issueLast = (ptr == curLen - 1'b1);
    status.ptrZero   = (ptr == '0);
    status.roomRx    = ptr < curLen;
  end

  assign memAddr  = curBase + ADDR_W'(ptr);
  assign memWdata = rxData;

  // CPU read-back
  epDesc_t rdDesc;
  always_comb begin
    rdDesc    = (int'(cfgRdEp) < NUM_EP) ? epTab[cfgRdEp] : '0;
    cfgRdData = '0;
    case (cfgFld_e'(cfgRdSel))
      FLD_ADDR0: cfgRdData = CFG_W'(rdDesc.addr[0]);
      FLD_CNT0:  cfgRdData = CFG_W'(rdDesc.cnt[0]);
      FLD_ADDR1: cfgRdData = CFG_W'(rdDesc.addr[1]);
      FLD_CNT1:  cfgRdData = CFG_W'(rdDesc.cnt[1]);
      FLD_MODE:  cfgRdData = CFG_W'({rdDesc.tog, rdDesc.dirIn, rdDesc.dbl});
      FLD_ARM:   cfgRdData = CFG_W'(rdDesc.armed);
      FLD_OVR:   cfgRdData = CFG_W'(rdDesc.ovr);
      default:   cfgRdData = '0;
    endcase
  end

endmodule

// File: rtl/ubm_ctrl.sv
module ubm_ctrl
  import ubm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqIn,
  input  ubmStatus_t status,
  input  logic       txReady,
  input  logic       rxValid,
  input  logic       rxEop,
  output ubmStrobe_t strobe,
  output logic       reqNak,
  output logic       doneOk,
  output logic       doneOvr,
  output logic       txValid,
  output logic       txSop,
  output logic       txEop,
  output logic       rxReady,
  output logic       memRe,
  output logic       memWe
);

  ubmState_e state, stateNxt;
  logic txValidQ, txLastQ, txSopQ, ovrHitQ;
  logic nakQ, okQ, ovrQ;
  logic txFire, issue;

  assign txFire = txValidQ && txReady;

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    issue    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid && status.slotOk) begin
          strobe.load = 1'b1;
          stateNxt    = reqIn ? ST_TX : ST_RX;
        end
      end
      ST_TX: begin
        issue          = status.moreTx && (!txValidQ || txFire);
        strobe.rdIssue = issue;
        if ((txFire && txLastQ) || (!status.moreTx && !txValidQ)) begin
          strobe.commit = 1'b1;
          stateNxt      = ST_IDLE;
        end
      end
      ST_RX: begin
        if (rxValid) begin
          strobe.wrByte = status.roomRx;
          if (rxEop) begin
            if (ovrHitQ || !status.roomRx) strobe.flagOvr = 1'b1;
            else                           strobe.commit  = 1'b1;
            stateNxt = ST_IDLE;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      txValidQ <= 1'b0;
      txLastQ  <= 1'b0;
      txSopQ   <= 1'b0;
      ovrHitQ  <= 1'b0;
      nakQ     <= 1'b0;
      okQ      <= 1'b0;
      ovrQ     <= 1'b0;
    end else begin
      state <= stateNxt;
      nakQ  <= (state == ST_IDLE) && reqValid && !status.slotOk;
      okQ   <= strobe.commit;
      ovrQ  <= strobe.flagOvr;
      if (issue) begin
        txValidQ <= 1'b1;
        txLastQ  <= status.issueLast;
        txSopQ   <= status.ptrZero;
      end else if (txFire) begin
        txValidQ <= 1'b0;
      end
      if (strobe.load) ovrHitQ <= 1'b0;
      else if ((state == ST_RX) && rxValid && !status.roomRx) ovrHitQ <= 1'b1;
    end
  end

  assign reqNak  = nakQ;
  assign doneOk  = okQ;
  assign doneOvr = ovrQ;
  assign txValid = txValidQ;
  assign txSop   = txValidQ && txSopQ;
  assign txEop   = txValidQ && txLastQ;
  assign rxReady = (state == ST_RX);
  assign memRe   = strobe.rdIssue;
  assign memWe   = strobe.wrByte;

endmodule

// File: rtl/usb_epbuf_mgr.sv
module usb_epbuf_mgr
  import ubm_pkg::*;
#(
  parameter int NUM_EP    = 10,
  parameter int MEM_BYTES = 2048,
  parameter int CNT_W     = 10,
  parameter int CFG_W     = 16,
  localparam int ADDR_W   = $clog2(MEM_BYTES),
  localparam int EP_W     = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [EP_W-1:0]   cfgEp,
  input  logic [2:0]        cfgSel,
  input  logic [CFG_W-1:0]  cfgWdata,
  input  logic [EP_W-1:0]   cfgRdEp,
  input  logic [2:0]        cfgRdSel,
  output logic [CFG_W-1:0]  cfgRdData,
  input  logic              reqValid,
  input  logic [EP_W-1:0]   reqEp,
  input  logic              reqIn,
  output logic              reqNak,
  output logic              doneOk,
  output logic              doneOvr,
  output logic              txValid,
  input  logic              txReady,
  output logic [7:0]        txData,
  output logic              txSop,
  output logic              txEop,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [7:0]        rxData,
  input  logic              rxEop,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata
);

  ubmStrobe_t strobe;
  ubmStatus_t status;

  ubm_datapath #(
    .NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .EP_W(EP_W), .CFG_W(CFG_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgEp(cfgEp), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .cfgRdEp(cfgRdEp), .cfgRdSel(cfgRdSel), .cfgRdData(cfgRdData),
    .reqEp(reqEp), .reqIn(reqIn), .rxData(rxData),
    .strobe(strobe), .status(status),
    .memAddr(memAddr), .memWdata(memWdata)
  );

  ubm_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqIn(reqIn), .status(status),
    .txReady(txReady), .rxValid(rxValid), .rxEop(rxEop),
    .strobe(strobe),
    .reqNak(reqNak), .doneOk(doneOk), .doneOvr(doneOvr),
    .txValid(txValid), .txSop(txSop), .txEop(txEop),
    .rxReady(rxReady), .memRe(memRe), .memWe(memWe)
  );

  assign txData = memRdata;

endmodule

// File: rtl/ubm_checker.sv
module ubm_checker #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqNak,
  input logic              doneOk,
  input logic              doneOvr,
  input logic              txValid,
  input logic              txReady,
  input logic [7:0]        txData,
  input logic              txEop,
  input logic              rxValid,
  input logic              rxReady,
  input logic              rxEop,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRe,
  input logic              memWe
);

  AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({reqNak, doneOk, doneOvr})); // R11

  AST_WRITE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> (memAddr == ADDR_W'($past(memAddr) + 1'b1))); // R4

  AST_WRITE_IN_RX: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (rxReady && rxValid)); // R4

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData) && $stable(txEop))); // R5

  AST_PORT_ONE_OP: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe)); // R5

  AST_OVR_AT_EOP: assert property (@(posedge clk) disable iff (!rstN)
    doneOvr |-> $past(rxValid && rxEop)); // R7

endmodule

bind usb_epbuf_mgr ubm_checker #(.ADDR_W(ADDR_W)) i_ubmChecker (
  .clk(clk), .rstN(rstN),
  .reqNak(reqNak), .doneOk(doneOk), .doneOvr(doneOvr),
  .txValid(txValid), .txReady(txReady), .txData(txData), .txEop(txEop),
  .rxValid(rxValid), .rxReady(rxReady), .rxEop(rxEop),
  .memAddr(memAddr), .memRe(memRe), .memWe(memWe)
);

// File: tb/test_usb_epbuf_mgr.sv
module test_usb_epbuf_mgr;

  localparam int NEP = 4;
  localparam int MB  = 64;
  localparam int CW  = 7;
  localparam int AW  = $clog2(MB);
  localparam int EW  = $clog2(NEP);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [EW-1:0] cfgEp = '0;
  logic [2:0] cfgSel = '0;
  logic [15:0] cfgWdata = '0;
  logic [EW-1:0] cfgRdEp = '0;
  logic [2:0] cfgRdSel = '0;
  logic [15:0] cfgRdData;
  logic reqValid = 1'b0;
  logic [EW-1:0] reqEp = '0;
  logic reqIn = 1'b0;
  logic reqNak, doneOk, doneOvr;
  logic txValid, txSop, txEop;
  logic txReady = 1'b1;
  logic [7:0] txData;
  logic rxValid = 1'b0;
  logic rxReady;
  logic [7:0] rxData = '0;
  logic rxEop = 1'b0;
  logic [AW-1:0] memAddr;
  logic memRe, memWe;
  logic [7:0] memWdata;
  logic [7:0] memRdata;

  int tests = 0;
  int fails = 0;
  logic stallOn = 1'b0;
  int cyc = 0;
  logic [9:0] txExp [$];
  logic [7:0] mem [MB];

  always #2.5 clk = ~clk;

  usb_epbuf_mgr #(.NUM_EP(NEP), .MEM_BYTES(MB), .CNT_W(CW), .CFG_W(16)) i_usb_epbuf_mgr (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgEp(cfgEp), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .cfgRdEp(cfgRdEp), .cfgRdSel(cfgRdSel), .cfgRdData(cfgRdData),
    .reqValid(reqValid), .reqEp(reqEp), .reqIn(reqIn), .reqNak(reqNak),
    .doneOk(doneOk), .doneOvr(doneOvr),
    .txValid(txValid), .txReady(txReady), .txData(txData), .txSop(txSop), .txEop(txEop),
    .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData), .rxEop(rxEop),
    .memAddr(memAddr), .memRe(memRe), .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata)
  );

  function automatic logic [7:0] pat(int i);
    return 8'(i * 7 + 3);
  endfunction

  // packet memory model: one-cycle read, output held when not reading
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MB; i++) mem[i] <= pat(i);
      memRdata <= '0;
    end else begin
      if (memWe) mem[memAddr] <= memWdata;
      if (memRe) memRdata <= mem[memAddr];
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    txReady <= !stallOn || (cyc % 3 != 0);
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected IN bytes as the design hands them over
  initial forever begin
    @(negedge clk);
    #1;
    if (rstN && txValid && txReady) begin
      if (txExp.size() == 0) check(1'b0, "R5 unexpected byte", int'(txData), 0);
      else begin
        logic [9:0] e;
        e = txExp.pop_front();
        check({txSop, txEop, txData} == e, "R5 byte/sop/eop", int'({txSop, txEop, txData}), int'(e));
      end
    end
  end

  task automatic cfgWrite(input int ep, input int sel, input int data);
    @(negedge clk);
    cfgWe = 1'b1; cfgEp = EW'(ep); cfgSel = 3'(sel); cfgWdata = 16'(data);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic cfgRead(input int ep, input int sel, output int val);
    cfgRdEp = EW'(ep); cfgRdSel = 3'(sel);
    #1;
    val = int'(cfgRdData);
  endtask

  task automatic request(input int ep, input logic dirIn, output logic nak);
    @(negedge clk);
    reqValid = 1'b1; reqEp = EW'(ep); reqIn = dirIn;
    @(negedge clk);
    reqValid = 1'b0;
    nak = reqNak;
  endtask

  // returns 0 nak, 1 ok, 2 overrun
  task automatic rxPacket(input int ep, input int n, input int first, output int res);
    logic nak;
    request(ep, 1'b0, nak);
    if (nak) begin res = 0; return; end
    for (int i = 0; i < n; i++) begin
      rxValid = 1'b1; rxData = 8'(first + i); rxEop = (i == n - 1);
      @(negedge clk);
    end
    rxValid = 1'b0; rxEop = 1'b0;
    res = doneOk ? 1 : (doneOvr ? 2 : 3);
  endtask

  task automatic txPacket(input int ep, input int base, input int n, output int res);
    logic nak;
    for (int i = 0; i < n; i++)
      txExp.push_back({(i == 0), (i == n - 1), pat((base + i) % MB)});
    request(ep, 1'b1, nak);
    if (nak) begin res = 0; txExp.delete(); return; end
    res = 3;
    for (int k = 0; k < 200; k++) begin
      if (doneOk) begin res = 1; break; end
      if (doneOvr) begin res = 2; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v, res;
    logic nak;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!reqNak && !doneOk && !doneOvr && !txValid && !rxReady, "R1 strobes", 0, 0);
    for (int s = 0; s < 7; s++) begin
      cfgRead(1, s, v);
      check(v == 0, "R1 descriptor field", v, 0);
    end

    // R5 single-mode IN on ep0, slot 0, with stalls
    cfgWrite(0, 0, 10); cfgWrite(0, 1, 5); cfgWrite(0, 5, 1);
    stallOn = 1'b1;
    txPacket(0, 10, 5, res);
    check(res == 1, "R11 IN done", res, 1);
    check(txExp.size() == 0, "R5 all bytes delivered", txExp.size(), 0);
    cfgRead(0, 5, v);
    check(v == 0, "R9 armed cleared", v, 0);
    stallOn = 1'b0;

    // R3 nak on unarmed slot, no data, no change
    request(0, 1'b1, nak);
    check(nak == 1'b1, "R3 nak unarmed", nak, 1);
    repeat (3) begin @(negedge clk); check(!txValid, "R3 no data after nak", txValid, 0); end
    cfgRead(0, 1, v);
    check(v == 5, "R3 count unchanged", v, 5);

    // R4 single-mode OUT on ep1 slot 1 with wrap
    cfgWrite(1, 2, 60); cfgWrite(1, 3, 10); cfgWrite(1, 5, 2);
    rxPacket(1, 8, 8'h40, res);
    check(res == 1, "R11 OUT done", res, 1);
    for (int i = 0; i < 8; i++)
      check(mem[(60 + i) % MB] == 8'(8'h40 + i), "R4 byte placement", mem[(60 + i) % MB], 8'h40 + i);
    check(mem[4] == pat(4), "R4 no write past packet", mem[4], pat(4));
    cfgRead(1, 3, v);
    check(v == 8, "R6 count writeback", v, 8);

    // R7 overrun
    cfgWrite(1, 2, 20); cfgWrite(1, 3, 3); cfgWrite(1, 5, 2);
    rxPacket(1, 5, 8'h80, res);
    check(res == 2, "R7 overrun result", res, 2);
    for (int i = 0; i < 3; i++)
      check(mem[20 + i] == 8'(8'h80 + i), "R7 bytes inside limit", mem[20 + i], 8'h80 + i);
    check(mem[23] == pat(23), "R7 byte beyond limit blocked", mem[23], pat(23));
    cfgRead(1, 5, v);
    check(v == 2, "R7 slot stays armed", v, 2);
    cfgRead(1, 3, v);
    check(v == 3, "R7 count unchanged", v, 3);
    cfgRead(1, 6, v);
    check(v == 1, "R8 overrun flag set", v, 1);
    rxPacket(1, 2, 8'h90, res);
    check(res == 1, "R8 later packet ok", res, 1);
    cfgRead(1, 6, v);
    check(v == 1, "R8 flag sticky", v, 1);
    cfgWrite(1, 6, 0);
    cfgRead(1, 6, v);
    check(v == 0, "R8 flag cleared by write", v, 0);

    // R2 ping-pong OUT on ep2
    cfgWrite(2, 4, 1);
    cfgWrite(2, 0, 30); cfgWrite(2, 1, 8);
    cfgWrite(2, 2, 40); cfgWrite(2, 3, 8);
    cfgWrite(2, 5, 3);
    rxPacket(2, 2, 8'h10, res);
    check(res == 1 && mem[30] == 8'h10 && mem[31] == 8'h11, "R2 first slot by toggle", mem[30], 8'h10);
    cfgRead(2, 4, v);
    check(v == 5, "R9 toggle flipped", v, 5);
    rxPacket(2, 3, 8'h20, res);
    check(res == 1 && mem[40] == 8'h20 && mem[42] == 8'h22, "R2 second slot by toggle", mem[40], 8'h20);
    cfgRead(2, 1, v);
    check(v == 2, "R6 count slot 0", v, 2);
    cfgRead(2, 3, v);
    check(v == 3, "R6 count slot 1", v, 3);
    rxPacket(2, 1, 8'h30, res);
    check(res == 0, "R3 nak both slots used", res, 0);
    cfgWrite(2, 5, 1);
    request(2, 1'b1, nak);
    check(nak == 1'b1, "R3 nak wrong direction", nak, 1);
    rxPacket(2, 1, 8'h33, res);
    check(res == 1 && mem[30] == 8'h33, "R2 toggle back to slot 0", mem[30], 8'h33);

    // R10 zero-length IN, then ping-pong IN slot 1 on ep3
    cfgWrite(3, 4, 3);
    cfgWrite(3, 0, 48); cfgWrite(3, 1, 0);
    cfgWrite(3, 2, 50); cfgWrite(3, 3, 3);
    cfgWrite(3, 5, 3);
    txPacket(3, 48, 0, res);
    check(res == 1, "R10 zero-length ok", res, 1);
    check(txExp.size() == 0, "R10 no bytes", txExp.size(), 0);
    txPacket(3, 50, 3, res);
    check(res == 1, "R2 ping-pong IN slot 1", res, 1);
    check(txExp.size() == 0, "R5 ping-pong bytes", txExp.size(), 0);
    cfgRead(3, 5, v);
    check(v == 0, "R9 both IN slots released", v, 0);
    @(negedge clk);
    check(!doneOk && !doneOvr && !reqNak, "R11 pulses single cycle", 0, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule